// File: doc/BRIEF.md
# Bi-endian load/store lane steering

This block sits between a 64-bit core and a 64-bit-wide data memory and moves data between register bit positions and memory byte lanes. On the store side it takes a register value, an address, an access size and the current byte-order mode. In the same cycle it produces the write word with the value placed in the correct lanes, plus one write enable per lane. On the load side it takes the word returned by memory together with the address, size, signedness and mode of that access. It picks out the addressed bytes, puts them in value order and zero- or sign-extends them to 64 bits. The result is registered and presented one cycle later with a valid strobe.

The byte-order mode is a plain input that may change from one access to the next. The same address and size therefore land in different lanes depending on the mode. Registers have no byte order: only the mapping between memory offsets and lanes changes. An access whose address is not a multiple of its size is flagged and is never split.

Top module: `lane_steer_top`

## Requirements
- R1: Size code 0, 1, 2 and 3 selects an access of 1, 2, 4 and 8 bytes. An aligned store asserts exactly that many bits of the 8-bit lane-enable vector, and they are contiguous.
- R2: With `big_end`=0, memory offset k within the doubleword is lane k (bits 8k+7:8k). The least significant value byte is at the lowest offset.
- R3: With `big_end`=1, memory offset k is lane 7-k, so offset 0 is bits 63:56. The most significant value byte is at the lowest offset.
- R4: On a store, `mem_wdata` holds the low bytes of `st_data` in the enabled lanes, in the order set by R2/R3, and zero in all other lanes.
- R5: A load returns the addressed bytes in value order. After a word store of 0x12345678 at offset 0, byte loads at offsets 0..3 return 78,56,34,12 in little-endian mode and 12,34,56,78 in big-endian mode.
- R6: A signed load (`rd_signed`=1) copies the top loaded bit into every higher bit of `ld_data`.
- R7: An unsigned load fills every bit of `ld_data` above the loaded bytes with zero.
- R8: A store whose address offset is not a multiple of its size raises `st_misalign`, drives all lane enables low and drives `mem_wdata` to zero.
- R9: A misaligned load sets `ld_misalign` alongside `ld_valid`, and `ld_data` is zero.
- R10: `ld_valid` is high in the cycle after `rd_valid` was sampled high and low otherwise. `ld_data` and `ld_misalign` belong to that response.
- R11: While `rst` is high and after it, until the first response, `ld_valid`, `ld_misalign` and `ld_data` are zero.
- R12: The byte-order mode may change between consecutive accesses, and each access uses the mode present with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_end | input | 1 | Byte-order mode, 1 = big-endian |
| st_en | input | 1 | Store request this cycle |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Register value to store |
| mem_wdata | output | 64 | Lane-steered write word |
| mem_be | output | 8 | Per-lane write enables |
| st_misalign | output | 1 | Store address not aligned to size |
| rd_valid | input | 1 | Memory returns load data this cycle |
| rd_addr | input | 32 | Load byte address |
| rd_size | input | 2 | Load size code |
| rd_signed | input | 1 | Sign-extend the loaded value |
| rd_data | input | 64 | Word returned by memory |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended register value |
| ld_misalign | output | 1 | Load address not aligned to size |

## Verification
Store results (`mem_wdata`, `mem_be`, `st_misalign`) depend only on the present inputs. The bench drives them at a falling edge and samples them 1 ns later, with no clock edge in between. Load results pass through one register, so the bench presents a response at a falling edge and samples `ld_*` 1 ns after the next rising edge. It then drops `rd_valid` and checks that `ld_valid` falls one edge later. Expected words come from a per-offset mapping function in the bench. The end-to-end byte-order cases go through a bench memory word updated only through the design's enabled lanes.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 32;
  localparam int NB     = DATA_W / 8;
  localparam int OFF_W  = $clog2(NB);
  localparam int SZ_W   = $clog2(OFF_W + 1);

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_map.sv
// Offset/size/mode to first lane, lane mask and alignment fault.
module lane_map #(
  parameter int NB    = 8,
  parameter int OFF_W = $clog2(NB),
  parameter int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  input  logic             big,
  output logic [OFF_W-1:0] base,
  output logic [NB-1:0]    mask,
  output logic             misal
);
  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] be_base;

  always_comb begin
    nbytes  = (OFF_W+1)'(1) << size;
    misal   = |(off & nbytes[OFF_W-1:0] - OFF_W'(1));
    // value byte j sits in lane base+j for both orders
    be_base = (OFF_W+1)'(NB) - nbytes - {1'b0, off};
    base    = big ? be_base[OFF_W-1:0] : off;
    for (int i = 0; i < NB; i++) begin
      mask[i] = (i >= int'(base)) && (i < int'(base) + int'(nbytes));
    end
  end
endmodule

// File: rtl/store_steer.sv
module store_steer #(
  parameter int NB    = 8,
  parameter int OFF_W = $clog2(NB)
) (
  input  logic              en,
  input  logic [8*NB-1:0]   data,
  input  logic [OFF_W-1:0]  base,
  input  logic [NB-1:0]     mask,
  output logic [8*NB-1:0]   wdata,
  output logic [NB-1:0]     be
);
  logic [8*NB-1:0] shifted;

  always_comb begin
    shifted = data << {base, 3'b000};
    be      = en ? mask : '0;
    for (int i = 0; i < NB; i++) begin
      wdata[i*8 +: 8] = be[i] ? shifted[i*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/load_extract.sv
module load_extract #(
  parameter int NB    = 8,
  parameter int OFF_W = $clog2(NB),
  parameter int SZ_W  = $clog2(OFF_W + 1)
) (
  input  logic [8*NB-1:0]  rdata,
  input  logic [OFF_W-1:0] base,
  input  logic [SZ_W-1:0]  size,
  input  logic             sgn,
  output logic [8*NB-1:0]  value
);
  logic [8*NB-1:0] shifted;
  logic [OFF_W:0]  nbytes;
  logic            msb;
  logic [7:0]      fill;

  always_comb begin
    shifted = rdata >> {base, 3'b000};
    nbytes  = (OFF_W+1)'(1) << size;
    msb     = 1'b0;
    for (int k = 0; k < NB; k++) begin
      if (k == int'(nbytes) - 1) msb = shifted[k*8+7];
    end
    fill = (sgn && msb) ? 8'hFF : 8'h00;
    for (int k = 0; k < NB; k++) begin
      value[k*8 +: 8] = (k < int'(nbytes)) ? shifted[k*8 +: 8] : fill;
    end
  end
endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_steer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int NBY = DW / 8,
  localparam int OW  = $clog2(NBY),
  localparam int SW  = $clog2(OW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          big_end,
  input  logic          st_en,
  input  logic [AW-1:0] st_addr,
  input  logic [SW-1:0] st_size,
  input  logic [DW-1:0] st_data,
  output logic [DW-1:0] mem_wdata,
  output logic [NBY-1:0] mem_be,
  output logic          st_misalign,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] rd_size,
  input  logic          rd_signed,
  input  logic [DW-1:0] rd_data,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data,
  output logic          ld_misalign
);
  logic [OW-1:0]  s_base, l_base;
  logic [NBY-1:0] s_mask, l_mask;
  logic           s_mis, l_mis;
  logic [DW-1:0]  l_value;

  lane_map #(.NB(NBY), .OFF_W(OW), .SZ_W(SW)) u_smap (
    .off(st_addr[OW-1:0]), .size(st_size), .big(big_end),
    .base(s_base), .mask(s_mask), .misal(s_mis)
  );

  store_steer #(.NB(NBY), .OFF_W(OW)) u_store (
    .en(st_en && !s_mis), .data(st_data), .base(s_base), .mask(s_mask),
    .wdata(mem_wdata), .be(mem_be)
  );

  assign st_misalign = st_en && s_mis;

  lane_map #(.NB(NBY), .OFF_W(OW), .SZ_W(SW)) u_lmap (
    .off(rd_addr[OW-1:0]), .size(rd_size), .big(big_end),
    .base(l_base), .mask(l_mask), .misal(l_mis)
  );

  load_extract #(.NB(NBY), .OFF_W(OW), .SZ_W(SW)) u_load (
    .rdata(rd_data), .base(l_base), .size(rd_size), .sgn(rd_signed),
    .value(l_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid    <= 1'b0;
      ld_data     <= '0;
      ld_misalign <= 1'b0;
    end else begin
      ld_valid    <= rd_valid;
      ld_misalign <= rd_valid && l_mis;
      if (rd_valid) ld_data <= l_mis ? '0 : l_value;
    end
  end

  logic unused_mask;
  assign unused_mask = ^{l_mask, st_addr[AW-1:OW], rd_addr[AW-1:OW]};
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int DW = 64,
  localparam int NBY = DW / 8
) (
  input logic           clk,
  input logic           rst,
  input logic           st_en,
  input logic [1:0]     st_size,
  input logic [DW-1:0]  mem_wdata,
  input logic [NBY-1:0] mem_be,
  input logic           st_misalign,
  input logic           rd_valid,
  input logic [1:0]     rd_size,
  input logic           rd_signed,
  input logic           ld_valid,
  input logic [DW-1:0]  ld_data,
  input logic           ld_misalign
);
  p_be_count_r1: assert property (@(posedge clk) disable iff (rst)
    (st_en && !st_misalign) |-> ($countones(mem_be) == (1 << st_size)));

  p_no_be_misal_r8: assert property (@(posedge clk) disable iff (rst)
    st_misalign |-> (mem_be == '0 && mem_wdata == '0));

  p_idle_no_be_r8: assert property (@(posedge clk) disable iff (rst)
    !st_en |-> (mem_be == '0 && !st_misalign));

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> ld_valid);

  p_valid_drops_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (!ld_valid && !ld_misalign));

  p_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_signed && rd_size == 2'd0) |=> (ld_data[DW-1:8] == '0));

  p_misal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ld_misalign |-> (ld_valid && ld_data == '0));
endmodule

bind lane_steer_top lane_steer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .st_en(st_en), .st_size(st_size),
  .mem_wdata(mem_wdata), .mem_be(mem_be), .st_misalign(st_misalign),
  .rd_valid(rd_valid), .rd_size(rd_size), .rd_signed(rd_signed),
  .ld_valid(ld_valid), .ld_data(ld_data), .ld_misalign(ld_misalign)
);

// File: tb/lane_steer_top_test.sv
`timescale 1ns/1ps
module lane_steer_top_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        big_end = 0, st_en = 0, rd_valid = 0, rd_signed = 0;
  logic [31:0] st_addr = 0, rd_addr = 0;
  logic [1:0]  st_size = 0, rd_size = 0;
  logic [63:0] st_data = 0, rd_data = 0;
  logic [63:0] mem_wdata, ld_data;
  logic [7:0]  mem_be;
  logic        st_misalign, ld_valid, ld_misalign;
  int checks = 0, fails = 0;
  logic [63:0] memword;

  always #2 clk = ~clk;

  lane_steer_top uut (.*);

  function automatic int lane_of(input int offs, input logic big);
    return big ? 7 - offs : offs;
  endfunction

  function automatic logic misal(input int off, input int sz);
    return (off % (1 << sz)) != 0;
  endfunction

  function automatic logic [7:0] exp_be(input int off, input int sz, input logic big);
    logic [7:0] b = 0;
    if (misal(off, sz)) return 0;
    for (int j = 0; j < (1 << sz); j++) b[lane_of(off + j, big)] = 1'b1;
    return b;
  endfunction

  function automatic logic [63:0] exp_wd(input logic [63:0] d, input int off,
                                         input int sz, input logic big);
    logic [63:0] w = 0;
    int n = 1 << sz;
    if (misal(off, sz)) return 0;
    for (int j = 0; j < n; j++)
      w[lane_of(off + (big ? n-1-j : j), big)*8 +: 8] = d[j*8 +: 8];
    return w;
  endfunction

  function automatic logic [63:0] exp_ld(input logic [63:0] m, input int off,
                                         input int sz, input logic big, input logic sg);
    logic [63:0] v = 0;
    int n = 1 << sz;
    if (misal(off, sz)) return 0;
    for (int j = 0; j < n; j++)
      v[j*8 +: 8] = m[lane_of(off + (big ? n-1-j : j), big)*8 +: 8];
    if (sg && v[n*8-1])
      for (int b = n*8; b < 64; b++) v[b] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [63:0] d, input int off, input int sz,
                          input logic big, input string req);
    @(negedge clk);
    big_end = big; st_en = 1; st_addr = 32'h1000 + off; st_size = sz[1:0]; st_data = d;
    #1;
    chk(req, {56'd0, mem_be}, {56'd0, exp_be(off, sz, big)});
    chk(req, mem_wdata, exp_wd(d, off, sz, big));
    chk(req, {63'd0, st_misalign}, {63'd0, misal(off, sz)});
    for (int i = 0; i < 8; i++) if (mem_be[i]) memword[i*8 +: 8] = mem_wdata[i*8 +: 8];
    st_en = 0;
  endtask

  task automatic do_load(input logic [63:0] m, input int off, input int sz,
                         input logic big, input logic sg, input string req);
    @(negedge clk);
    big_end = big; rd_valid = 1; rd_addr = 32'h2000 + off; rd_size = sz[1:0];
    rd_signed = sg; rd_data = m;
    @(posedge clk); #1;
    rd_valid = 0;
    chk(req, {63'd0, ld_valid}, 64'd1);
    chk(req, ld_data, exp_ld(m, off, sz, big, sg));
    chk(req, {63'd0, ld_misalign}, {63'd0, misal(off, sz)});
  endtask

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset", {ld_data[62:0], ld_valid}, 64'd0);
    chk("R11 reset", {63'd0, ld_misalign}, 64'd0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R11 after reset", {63'd0, ld_valid}, 64'd0);

    // R5 R2 R3 R12: word store then byte loads, both orders back to back
    for (int mode = 0; mode < 2; mode++) begin
      memword = 64'hAAAA_AAAA_AAAA_AAAA;
      do_store(64'h0000_0000_1234_5678, 0, 2, mode[0], "R5 word store");
      for (int k = 0; k < 4; k++) begin
        logic [7:0] want;
        want = mode ? 8'h12 + 8'h22 * k[7:0] : 8'h78 - 8'h22 * k[7:0];
        do_load(memword, k, 0, mode[0], 0, "R5 byte readback");
        chk("R5 R12 literal byte", ld_data, {56'd0, want});
      end
    end
    // R3 offset 0 in big-endian is bits 63:56
    do_load(64'h8100_0000_0000_0011, 0, 0, 1, 0, "R3 top lane");
    chk("R3 top lane literal", ld_data, 64'h81);
    do_load(64'h8100_0000_0000_0011, 0, 0, 0, 0, "R2 low lane");
    chk("R2 low lane literal", ld_data, 64'h11);
    // R6 R7 corner: sign bit set
    do_load(64'h0000_0000_0000_8000, 0, 1, 0, 1, "R6 signed half");
    chk("R6 literal", ld_data, 64'hFFFF_FFFF_FFFF_8000);
    do_load(64'h0000_0000_0000_8000, 0, 1, 0, 0, "R7 unsigned half");
    chk("R7 literal", ld_data, 64'h8000);
    // R8 R9 directed misaligned
    do_store(64'hFFFF_FFFF_FFFF_FFFF, 2, 2, 0, "R8 misaligned store");
    do_load(64'h1234_5678_9ABC_DEF0, 6, 3, 1, 1, "R9 misaligned load");
    // R1 R4 doubleword both modes
    do_store(64'h0102_0304_0506_0708, 0, 3, 0, "R1 R4 dword LE");
    do_store(64'h0102_0304_0506_0708, 0, 3, 1, "R1 R4 dword BE");
    // R10 valid drops after idle cycle
    @(negedge clk); @(posedge clk); #1;
    chk("R10 valid low when idle", {63'd0, ld_valid}, 64'd0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int off, sz;
      logic big, sg;
      logic [63:0] d;
      off = int'($urandom_range(0, 7));
      sz  = int'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) off = off & ~((1 << sz) - 1);
      big = 1'($urandom);
      sg  = 1'($urandom);
      d   = {$urandom, $urandom};
      if (it % 2 == 0) do_store(d, off, sz, big, "R4 random store");
      else             do_load(d, off, sz, big, sg, "R6 R7 random load");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule